// File: doc/BRIEF.md
# Multi-Latency Execution Cluster

This block is the execute stage of an in-order pipeline. It takes at most one instruction per cycle over a valid/ready handshake. Each instruction carries an operation class, a destination register tag, two source register tags and two 32-bit operand values. The block sends the instruction to one of four units, each with a fixed latency:

- a single-cycle logic unit;
- a four-stage pipelined adder;
- a seven-stage pipelined multiplier;
- a 24-cycle divider that is not pipelined.

All results come back on one shared writeback port as a valid, a tag and a value. Because the latencies differ, results can leave in a different order from the one in which instructions were accepted.

Issue order is kept by refusing an instruction until it is safe to start. There are four reasons to hold it back:

- a source tag still waits for an older result;
- the destination tag still waits for an older result;
- the writeback cycle the instruction would need is already reserved;
- the divider is occupied.

A 32-entry pending scoreboard tracks the tags. A 25-slot reservation shift register tracks future writeback cycles. The upstream stage keeps the instruction on the inputs until `in_ready_o` is high. The instruction is accepted on the clock edge where `in_valid_i` and `in_ready_o` are both high.

Top module: `exec_cluster`

## Requirements
- R1: After reset, or after a reset that arrives while operations are in flight, `wb_valid_o` is low and no earlier operation ever writes back. No tag is pending, so a new instruction is accepted without stalling.
- R2: Class 0 (logic) returns `opa XOR opb`. Its writeback appears in the cycle right after the acceptance cycle (latency 1).
- R3: Class 1 (add) returns `opa + opb` modulo 2^32 with latency 4. The adder can take a new add in every cycle.
- R4: Class 2 (multiply) returns the low 32 bits of `opa * opb` with latency 7. The multiplier can take a new multiply in every cycle.
- R5: Class 3 (divide) returns the unsigned quotient `opa / opb` with latency 24. If `opb` is zero it returns 32'hFFFF_FFFF.
- R6: While a divide is in progress, a second divide is refused. The earliest cycle it can be accepted is the cycle in which the first divide writes back.
- R7: An instruction whose source tag waits for an older result is held back. It is accepted in the cycle in which that result is written back.
- R8: An instruction whose destination tag waits for an older result is held back until that writeback. The younger result is therefore the last one written to that tag.
- R9: An instruction whose completion cycle is already reserved on the writeback port is held back for as many cycles as it takes to find a free slot. At most one result leaves per cycle.
- R10: Independent instructions complete out of program order when a later one has a shorter latency. For example, a logic operation accepted after a divide writes back first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Instruction offered |
| in_ready_o | output | 1 | Instruction can be accepted this cycle |
| in_op_i | input | 2 | Operation class: 0 logic, 1 add, 2 multiply, 3 divide |
| in_dst_i | input | 5 | Destination register tag |
| in_src_a_i | input | 5 | First source register tag |
| in_src_b_i | input | 5 | Second source register tag |
| in_opa_i | input | 32 | First operand value |
| in_opb_i | input | 32 | Second operand value |
| wb_valid_o | output | 1 | Result present on writeback port |
| wb_tag_o | output | 5 | Destination tag of the result |
| wb_data_o | output | 32 | Result value |

## Verification
Suppose a pending bit is set or cleared in the wrong cycle. It shows up as `in_ready_o` staying low too long, or rising too early, while a dependent instruction waits. The bench sees this as an acceptance cycle that differs from the producer's writeback cycle.

Suppose the reservation register or a unit delay line is off by one. A result then appears one cycle early or late, or two units produce a result in the same cycle. This becomes visible on the writeback port within the unit's latency, at most 24 cycles after acceptance.

A divider counter that frees the divider too early lets a second divide in before the first writes back. The bench sees this as a wrong acceptance cycle for the second divide.

// File: rtl/exec_pkg.sv
package exec_pkg;
  typedef enum logic [1:0] {
    OP_LOGIC = 2'd0,
    OP_ADD   = 2'd1,
    OP_MUL   = 2'd2,
    OP_DIV   = 2'd3
  } op_e;
endpackage

// File: rtl/exec_pipe.sv
module exec_pipe #(
  parameter int LAT    = 4,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [DATA_W-1:0] dat_i,
  output logic              vld_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [DATA_W-1:0] dat_o
);
  logic [LAT-1:0]    vld_q;
  logic [TAG_W-1:0]  tag_q [LAT];
  logic [DATA_W-1:0] dat_q [LAT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else begin
      vld_q[0] <= vld_i;
      for (int s = 1; s < LAT; s++) vld_q[s] <= vld_q[s-1];
    end
  end

  always_ff @(posedge clk_i) begin
    tag_q[0] <= tag_i;
    dat_q[0] <= dat_i;
    for (int s = 1; s < LAT; s++) begin
      tag_q[s] <= tag_q[s-1];
      dat_q[s] <= dat_q[s-1];
    end
  end

  assign vld_o = vld_q[LAT-1];
  assign tag_o = tag_q[LAT-1];
  assign dat_o = dat_q[LAT-1];
endmodule

// File: rtl/exec_div.sv
module exec_div #(
  parameter int LAT    = 24,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [DATA_W-1:0] dat_i,
  output logic              busy_o,
  output logic              vld_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [DATA_W-1:0] dat_o
);
  localparam int CNT_W = $clog2(LAT + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= CNT_W'(LAT);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (start_i) begin
      tag_q <= tag_i;
      dat_q <= dat_i;
    end
  end

  // last cycle overlaps the next start
  assign busy_o = cnt_q > CNT_W'(1);
  assign vld_o  = cnt_q == CNT_W'(1);
  assign tag_o  = tag_q;
  assign dat_o  = dat_q;

  // R6
  div_no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> cnt_q <= CNT_W'(1));
endmodule

// File: rtl/exec_scoreboard.sv
module exec_scoreboard #(
  parameter int NREG  = 32,
  parameter int DEPTH = 25,
  localparam int TAG_W = $clog2(NREG),
  localparam int LAT_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic [LAT_W-1:0] lat_i,
  input  logic [TAG_W-1:0] dst_i,
  input  logic [TAG_W-1:0] src_a_i,
  input  logic [TAG_W-1:0] src_b_i,
  input  logic             wb_vld_i,
  input  logic [TAG_W-1:0] wb_tag_i,
  output logic             hazard_o,
  output logic             slot_busy_o
);
  logic [NREG-1:0]  pend_q, pend_eff, pend_d;
  logic [DEPTH-1:0] rsv_q, rsv_d;

  always_comb begin
    pend_eff = pend_q;
    if (wb_vld_i) pend_eff[wb_tag_i] = 1'b0;
    pend_d = pend_eff;
    if (fire_i) pend_d[dst_i] = 1'b1;
  end

  // rsv_q[k]: writeback claimed k cycles from now
  always_comb begin
    rsv_d = rsv_q >> 1;
    if (fire_i) rsv_d[int'(lat_i) - 1] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      rsv_q  <= '0;
    end else begin
      pend_q <= pend_d;
      rsv_q  <= rsv_d;
    end
  end

  assign hazard_o    = pend_eff[src_a_i] | pend_eff[src_b_i] | pend_eff[dst_i];
  assign slot_busy_o = rsv_q[lat_i];

  // R9
  wb_matches_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsv_q[0] == wb_vld_i);
  // R7
  wb_tag_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_vld_i |-> pend_q[wb_tag_i]);
endmodule

// File: rtl/exec_cluster.sv
module exec_cluster #(
  parameter int NREG    = 32,
  parameter int DATA_W  = 32,
  parameter int LAT_LOG = 1,
  parameter int LAT_ADD = 4,
  parameter int LAT_MUL = 7,
  parameter int LAT_DIV = 24,
  localparam int TAG_W  = $clog2(NREG),
  localparam int MAX_A  = (LAT_LOG > LAT_ADD) ? LAT_LOG : LAT_ADD,
  localparam int MAX_B  = (LAT_MUL > LAT_DIV) ? LAT_MUL : LAT_DIV,
  localparam int DEPTH  = ((MAX_A > MAX_B) ? MAX_A : MAX_B) + 1,
  localparam int LAT_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [1:0]        in_op_i,
  input  logic [TAG_W-1:0]  in_dst_i,
  input  logic [TAG_W-1:0]  in_src_a_i,
  input  logic [TAG_W-1:0]  in_src_b_i,
  input  logic [DATA_W-1:0] in_opa_i,
  input  logic [DATA_W-1:0] in_opb_i,
  output logic              wb_valid_o,
  output logic [TAG_W-1:0]  wb_tag_o,
  output logic [DATA_W-1:0] wb_data_o
);
  import exec_pkg::*;

  localparam int NU = 4;

  op_e              op;
  logic             fire, hazard, slot_busy, div_busy;
  logic [LAT_W-1:0] lat;
  logic [NU-1:0]    u_start, u_vld;
  logic [TAG_W-1:0] u_tag [NU];
  logic [DATA_W-1:0] u_res [NU];
  logic [DATA_W-1:0] u_out [NU];

  assign op = op_e'(in_op_i);

  always_comb begin
    unique case (op)
      OP_LOGIC: lat = LAT_W'(LAT_LOG);
      OP_ADD:   lat = LAT_W'(LAT_ADD);
      OP_MUL:   lat = LAT_W'(LAT_MUL);
      default:  lat = LAT_W'(LAT_DIV);
    endcase
  end

  assign u_res[OP_LOGIC] = in_opa_i ^ in_opb_i;
  assign u_res[OP_ADD]   = in_opa_i + in_opb_i;
  assign u_res[OP_MUL]   = in_opa_i * in_opb_i;
  assign u_res[OP_DIV]   = (in_opb_i == '0) ? '1 : in_opa_i / in_opb_i;

  assign in_ready_o = !hazard && !slot_busy && !(op == OP_DIV && div_busy);
  assign fire       = in_valid_i && in_ready_o;

  exec_scoreboard #(.NREG(NREG), .DEPTH(DEPTH)) u_sb (
    .clk_i, .rst_ni,
    .fire_i(fire), .lat_i(lat),
    .dst_i(in_dst_i), .src_a_i(in_src_a_i), .src_b_i(in_src_b_i),
    .wb_vld_i(wb_valid_o), .wb_tag_i(wb_tag_o),
    .hazard_o(hazard), .slot_busy_o(slot_busy)
  );

  for (genvar u = 0; u < NU; u++) begin : g_unit
    assign u_start[u] = fire && (in_op_i == 2'(u));
    if (u == int'(OP_DIV)) begin : g_div
      exec_div #(.LAT(LAT_DIV), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_div (
        .clk_i, .rst_ni, .start_i(u_start[u]), .tag_i(in_dst_i), .dat_i(u_res[u]),
        .busy_o(div_busy), .vld_o(u_vld[u]), .tag_o(u_tag[u]), .dat_o(u_out[u])
      );
    end else begin : g_pipe
      localparam int L = (u == int'(OP_LOGIC)) ? LAT_LOG :
                         (u == int'(OP_ADD))   ? LAT_ADD : LAT_MUL;
      exec_pipe #(.LAT(L), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_pipe (
        .clk_i, .rst_ni, .vld_i(u_start[u]), .tag_i(in_dst_i), .dat_i(u_res[u]),
        .vld_o(u_vld[u]), .tag_o(u_tag[u]), .dat_o(u_out[u])
      );
    end
  end

  always_comb begin
    wb_valid_o = |u_vld;
    wb_tag_o   = '0;
    wb_data_o  = '0;
    for (int u = 0; u < NU; u++) begin
      if (u_vld[u]) begin
        wb_tag_o  = u_tag[u];
        wb_data_o = u_out[u];
      end
    end
  end

  // R9
  wb_single_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(u_vld));
  // R1
  idle_after_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !wb_valid_o);
endmodule

// File: tb/exec_cluster_tb.sv
module exec_cluster_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = 2'd0;
  logic [4:0]  in_dst = 5'd0, in_sa = 5'd30, in_sb = 5'd31;
  logic [31:0] in_a = '0, in_b = '0;
  logic        wb_valid;
  logic [4:0]  wb_tag;
  logic [31:0] wb_data;

  int checks = 0, fails = 0, cyc = 0;
  int tag_cyc [32];
  int tag_cnt [32];
  logic [31:0] tag_dat [32];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  exec_cluster u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_op_i(in_op), .in_dst_i(in_dst), .in_src_a_i(in_sa), .in_src_b_i(in_sb),
    .in_opa_i(in_a), .in_opb_i(in_b),
    .wb_valid_o(wb_valid), .wb_tag_o(wb_tag), .wb_data_o(wb_data)
  );

  always @(negedge clk) begin
    if (wb_valid) begin
      tag_cyc[wb_tag] = cyc;
      tag_dat[wb_tag] = wb_data;
      tag_cnt[wb_tag] = tag_cnt[wb_tag] + 1;
    end
  end

  typedef struct packed {
    logic [1:0]  op;
    logic [4:0]  dst;
    logic [31:0] a;
    logic [31:0] b;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 5'd1, 32'hF0F0_1234, 32'h0FF0_FFFF},
    '{2'd0, 5'd2, 32'h0000_0000, 32'hFFFF_FFFF},
    '{2'd1, 5'd3, 32'hFFFF_FFFF, 32'h0000_0002},
    '{2'd1, 5'd4, 32'h1234_5678, 32'h1111_1111},
    '{2'd2, 5'd5, 32'h0001_0001, 32'h0001_0001},
    '{2'd2, 5'd6, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    '{2'd3, 5'd7, 32'd1000,      32'd7},
    '{2'd3, 5'd8, 32'hDEAD_BEEF, 32'd0}
  };

  function automatic logic [31:0] exp_val(logic [1:0] op, logic [31:0] a, logic [31:0] b);
    case (op)
      2'd0: return a ^ b;
      2'd1: return a + b;
      2'd2: return a * b;
      default: return (b == 0) ? 32'hFFFF_FFFF : a / b;
    endcase
  endfunction

  function automatic int exp_lat(logic [1:0] op);
    case (op)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 7;
      default: return 24;
    endcase
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    for (int t = 0; t < 32; t++) begin
      tag_cnt[t] = 0; tag_cyc[t] = -1; tag_dat[t] = '0;
    end
  endtask

  // offers an instruction until accepted; ic = acceptance cycle, st = stall cycles
  task automatic send(logic [1:0] op, logic [4:0] dst, logic [4:0] sa, logic [4:0] sb,
                      logic [31:0] a, logic [31:0] b, output int ic, output int st);
    bit done = 0;
    in_valid = 1'b1; in_op = op; in_dst = dst; in_sa = sa; in_sb = sb; in_a = a; in_b = b;
    st = 0;
    while (!done) begin
      @(negedge clk);
      if (in_ready) begin
        ic = cyc;
        done = 1;
      end else st++;
      @(posedge clk); #1;
    end
    in_valid = 1'b0; in_sa = 5'd30; in_sb = 5'd31;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int c0, c1, c2, s0, s1;
    clear_log();
    idle(3);
    @(negedge clk);
    chk(wb_valid == 1'b0, "R1 wb idle in reset", wb_valid, 0);
    rst_n = 1'b1;
    idle(2);
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
    chk(wb_valid == 1'b0, "R1 no writeback after reset", wb_valid, 0);
    @(posedge clk); #1;

    // table walk: R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      clear_log();
      send(VECS[i].op, VECS[i].dst, 5'd30, 5'd31, VECS[i].a, VECS[i].b, c0, s0);
      idle(27);
      chk(tag_dat[VECS[i].dst] == exp_val(VECS[i].op, VECS[i].a, VECS[i].b),
          "R2/R3/R4/R5 result", tag_dat[VECS[i].dst],
          exp_val(VECS[i].op, VECS[i].a, VECS[i].b));
      chk(tag_cyc[VECS[i].dst] - c0 == exp_lat(VECS[i].op), "R2/R3/R4/R5 latency",
          tag_cyc[VECS[i].dst] - c0, exp_lat(VECS[i].op));
    end

    // R3 back-to-back adds
    clear_log();
    send(2'd1, 5'd14, 5'd30, 5'd31, 32'd5, 32'd6, c0, s0);
    send(2'd1, 5'd15, 5'd30, 5'd31, 32'd7, 32'd8, c1, s1);
    idle(10);
    chk(s1 == 0, "R3 add pipelined", s1, 0);
    chk(tag_cyc[15] == tag_cyc[14] + 1 && tag_dat[15] == 32'd15, "R3 second add",
        tag_dat[15], 15);

    // R4 back-to-back multiplies
    clear_log();
    send(2'd2, 5'd18, 5'd30, 5'd31, 32'd9, 32'd9, c0, s0);
    send(2'd2, 5'd19, 5'd30, 5'd31, 32'd3, 32'd11, c1, s1);
    idle(12);
    chk(s1 == 0, "R4 mul pipelined", s1, 0);
    chk(tag_cyc[19] == tag_cyc[18] + 1 && tag_dat[19] == 32'd33, "R4 second mul",
        tag_dat[19], 33);

    // R6 divider occupancy
    clear_log();
    send(2'd3, 5'd5, 5'd30, 5'd31, 32'd100, 32'd3, c0, s0);
    send(2'd3, 5'd6, 5'd30, 5'd31, 32'd100, 32'd9, c1, s1);
    chk(c1 - c0 == 24, "R6 second divide accepted at first writeback", c1 - c0, 24);
    idle(30);
    chk(tag_dat[6] == 32'd11 && tag_cyc[6] == c1 + 24, "R6 second divide result",
        tag_dat[6], 11);

    // R7 source dependency
    clear_log();
    send(2'd2, 5'd7, 5'd30, 5'd31, 32'd4, 32'd5, c0, s0);
    send(2'd0, 5'd8, 5'd7, 5'd31, 32'd1, 32'd2, c1, s1);
    chk(c1 == c0 + 7, "R7 consumer accepted in producer writeback cycle", c1 - c0, 7);
    idle(10);

    // R8 destination dependency
    clear_log();
    send(2'd3, 5'd9, 5'd30, 5'd31, 32'd50, 32'd5, c0, s0);
    send(2'd0, 5'd9, 5'd30, 5'd31, 32'hAAAA_0000, 32'h0000_5555, c1, s1);
    chk(c1 == c0 + 24, "R8 same destination held", c1 - c0, 24);
    idle(30);
    chk(tag_cnt[9] == 2 && tag_dat[9] == 32'hAAAA_5555, "R8 younger result last",
        tag_dat[9], 32'hAAAA_5555);

    // R9 writeback slot conflict
    clear_log();
    send(2'd2, 5'd10, 5'd30, 5'd31, 32'd6, 32'd7, c0, s0);
    send(2'd0, 5'd16, 5'd30, 5'd31, 32'd1, 32'd1, c1, s1);
    send(2'd0, 5'd17, 5'd30, 5'd31, 32'd2, 32'd2, c1, s1);
    send(2'd1, 5'd11, 5'd30, 5'd31, 32'd20, 32'd22, c2, s1);
    chk(c2 == c0 + 4 && s1 == 1, "R9 add held one cycle", c2 - c0, 4);
    idle(12);
    chk(tag_cyc[11] == c0 + 8 && tag_cyc[10] == c0 + 7, "R9 distinct writeback cycles",
        tag_cyc[11] - c0, 8);

    // R10 out-of-order completion
    clear_log();
    send(2'd3, 5'd12, 5'd30, 5'd31, 32'd81, 32'd9, c0, s0);
    send(2'd0, 5'd13, 5'd30, 5'd31, 32'd3, 32'd5, c1, s1);
    idle(30);
    chk(s1 == 0 && tag_cyc[13] < tag_cyc[12], "R10 short op finishes first",
        tag_cyc[13], tag_cyc[12]);
    chk(tag_dat[12] == 32'd9 && tag_dat[13] == 32'd6, "R10 both results",
        tag_dat[12], 9);

    // R1 reset while a divide is in flight
    clear_log();
    send(2'd3, 5'd20, 5'd30, 5'd31, 32'd10, 32'd2, c0, s0);
    idle(3);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(30);
    chk(tag_cnt[20] == 0, "R1 flushed divide never writes back", tag_cnt[20], 0);
    send(2'd0, 5'd21, 5'd20, 5'd31, 32'd1, 32'd0, c1, s1);
    chk(s1 == 0, "R1 tag no longer pending", s1, 0);
    idle(3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule